// File: doc/BRIEF.md
# Comparator-Triggered Interrupt and Timer Controller

This block is a small peripheral control unit for a microcontroller. A CPU reaches it over a port-addressed I/O bus. It holds a 16-bit control word at I/O address 0x38 and an interrupt flag word at I/O address 0x39. The block watches the digital output of an external comparator through a synchronizer and detects its high-to-low transitions. Each such transition sets the INT7 flag. It can also start a timer by turning on the timer run bit, but only when the INT6 flag and the run bit were both clear beforehand.

Each of the two flags, INT6 and INT7, raises a branch request when its mask bit in the control word is set. The INT7 request leads to vector 0x7FF7. A flag clears itself when the CPU acknowledges its own branch. Software can overwrite either flag at any time.

While the comparator is enabled, the block reports that port-D pins 4 and 5 serve as comparator inputs. Software must keep those pins configured as inputs. The analog comparator, the timer counter, the CPU and the vector fetch are outside this block.

Top module: `cmpirq_unit`

## Requirements
- R1: After reset both registers read as zero, both branch requests are low, and `timer_run` and `cmp_pins_owned` are low.
- R2: A read with `io_rd` high returns the register contents in the same cycle. At 0x38 the readable bits are 15, 10, 7 and 6. At 0x39 the readable bits are 7 (INT7 flag) and 6 (INT6 flag). Every other bit, every other address, and every cycle with `io_rd` low read as zero.
- R3: Control bit 15 enables the comparator and drives `cmp_pins_owned`. While bit 15 is clear, a comparator falling edge changes no flag and does not touch the timer.
- R4: The comparator input passes through a synchronizer of two flops. A 1-to-0 transition, while enabled, sets the INT7 flag (bit 7 of 0x39) exactly once. A held low level or a rising edge sets nothing.
- R5: Control bit 10 is the timer run control, where 1 means running. It is written by software and appears on `timer_run`.
- R6: An enabled falling edge sets bit 10 only if the INT6 flag and bit 10 were both clear in the cycle of the edge. A same-cycle software write to 0x38 takes priority.
- R7: `int7_req` is high while the INT7 flag and control bit 7 are both set (vector 0x7FF7). `int7_ack` clears the INT7 flag, and wins over a same-cycle comparator event.
- R8: The INT6 flag is set by a pulse on `int6_evt`. `int6_req` is high while the INT6 flag and control bit 6 are both set. `int6_ack` clears the INT6 flag, and wins over a same-cycle `int6_evt`.
- R9: A write to 0x39 loads both flags from `io_wdata[7]` and `io_wdata[6]`. It takes priority over any same-cycle hardware set or acknowledge.
- R10: An acknowledge for one vector neither clears nor blocks the other vector's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 8 | I/O port address |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 16 | I/O write data |
| io_rdata | output | 16 | I/O read data, combinational |
| cmp_in | input | 1 | Asynchronous comparator output |
| int6_evt | input | 1 | INT6 event pulse |
| int6_ack | input | 1 | INT6 branch taken |
| int7_ack | input | 1 | INT7 branch taken |
| int6_req | output | 1 | INT6 branch request |
| int7_req | output | 1 | INT7 branch request |
| timer_run | output | 1 | Timer run control, 1 = running |
| cmp_pins_owned | output | 1 | Port-D pins 4 and 5 are comparator inputs |

## Verification
The bench drives a falling edge while the comparator is disabled. A design that ignored bit 15 would set INT7 and start the timer there. It holds the comparator low for many cycles and then raises it. A level-sensitive detector would set INT7 again, and an edge-agnostic one would fire on the rise. It drives a falling edge while the INT6 flag is set, where a design missing that term of the start condition would start the timer. Finally it collides an acknowledge, a hardware set and a software write in one cycle. A wrong priority order would leave the flag in the wrong state, and a shared clear would wipe the other vector's flag.

// File: rtl/cmpirq_pkg.sv
package cmpirq_pkg;
  localparam logic [7:0] CTRL_ADDR  = 8'h38;
  localparam logic [7:0] FLAG_ADDR  = 8'h39;
  localparam int BIT_CMP_EN  = 15;
  localparam int BIT_TMR_RUN = 10;
  localparam int BIT_MASK7   = 7;
  localparam int BIT_MASK6   = 6;
  localparam int BIT_FLAG7   = 7;
  localparam int BIT_FLAG6   = 6;
  localparam int NUM_FLAGS   = 2;
  localparam logic [15:0] INT7_VECTOR = 16'h7FF7;
endpackage

// File: rtl/cmpirq_edge_det.sv
module cmpirq_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic async_in,
  output logic fall_pulse
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic prev_q, prev_d;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_comb sync_d = async_in;
    end else begin : g_chain
      always_comb sync_d = {sync_q[SYNC_STAGES-2:0], async_in};
    end
  endgenerate

  always_comb begin
    prev_d     = sync_q[LAST];
    fall_pulse = enable & prev_q & ~sync_q[LAST];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  // R4: one edge gives one event pulse
  assert_single_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fall_pulse |=> !fall_pulse);
endmodule

// File: rtl/cmpirq_flag.sv
module cmpirq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_wr,
  input  logic sw_val,
  input  logic hw_set,
  input  logic ack,
  output logic flag_q
);
  logic flag_d, flag_en;

  always_comb begin
    flag_en = sw_wr | ack | hw_set;
    if (sw_wr)       flag_d = sw_val;
    else if (ack)    flag_d = 1'b0;
    else             flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assert_sw_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr |=> flag_q == $past(sw_val));
  assert_ack_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack && !sw_wr |=> !flag_q);
  assert_hw_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set && !ack && !sw_wr |=> flag_q);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_wr && !ack && !hw_set |=> $stable(flag_q));
endmodule

// File: rtl/cmpirq_ctrl.sv
module cmpirq_ctrl
  import cmpirq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cmp_fall,
  input  logic              int6_flag,
  output logic [DATA_W-1:0] ctrl_view
);
  logic en_q, en_d, run_q, run_d, m7_q, m7_d, m6_q, m6_d;
  logic start, run_en;

  always_comb begin
    start  = cmp_fall & ~int6_flag & ~run_q;
    run_en = wr_en | start;
    run_d  = wr_en ? wdata[BIT_TMR_RUN] : 1'b1;
    en_d   = wdata[BIT_CMP_EN];
    m7_d   = wdata[BIT_MASK7];
    m6_d   = wdata[BIT_MASK6];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      m7_q <= 1'b0;
      m6_q <= 1'b0;
    end else if (wr_en) begin
      en_q <= en_d;
      m7_q <= m7_d;
      m6_q <= m6_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= 1'b0;
    else if (run_en) run_q <= run_d;
  end

  always_comb begin
    ctrl_view              = '0;
    ctrl_view[BIT_CMP_EN]  = en_q;
    ctrl_view[BIT_TMR_RUN] = run_q;
    ctrl_view[BIT_MASK7]   = m7_q;
    ctrl_view[BIT_MASK6]   = m6_q;
  end

  assert_timer_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_fall && !int6_flag && !ctrl_view[BIT_TMR_RUN] && !wr_en |=> ctrl_view[BIT_TMR_RUN]);
  assert_no_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_fall && int6_flag && !ctrl_view[BIT_TMR_RUN] && !wr_en |=> !ctrl_view[BIT_TMR_RUN]);
  assert_sw_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ctrl_view[BIT_TMR_RUN] == $past(wdata[BIT_TMR_RUN]));
endmodule

// File: rtl/cmpirq_unit.sv
module cmpirq_unit
  import cmpirq_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  input  logic              cmp_in,
  input  logic              int6_evt,
  input  logic              int6_ack,
  input  logic              int7_ack,
  output logic              int6_req,
  output logic              int7_req,
  output logic              timer_run,
  output logic              cmp_pins_owned
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(FLAG_ADDR);

  logic rst_meta_q, rst_sync_n;
  logic [DATA_W-1:0] ctrl_view, flag_view;
  logic ctrl_wr, flag_wr, cmp_fall, cmp_en;
  logic [NUM_FLAGS-1:0] f_set, f_ack, f_val, f_q, f_mask;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  always_comb begin
    ctrl_wr = io_wr & (io_addr == CTRL_A);
    flag_wr = io_wr & (io_addr == FLAG_A);
    cmp_en  = ctrl_view[BIT_CMP_EN];
  end

  cmpirq_edge_det #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
    .clk(clk), .rst_n(rst_sync_n), .enable(cmp_en),
    .async_in(cmp_in), .fall_pulse(cmp_fall));

  cmpirq_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(ctrl_wr), .wdata(io_wdata),
    .cmp_fall(cmp_fall), .int6_flag(f_q[0]), .ctrl_view(ctrl_view));

  // index 0 = INT6, index 1 = INT7
  always_comb begin
    f_set  = {cmp_fall, int6_evt};
    f_ack  = {int7_ack, int6_ack};
    f_val  = {io_wdata[BIT_FLAG7], io_wdata[BIT_FLAG6]};
    f_mask = {ctrl_view[BIT_MASK7], ctrl_view[BIT_MASK6]};
  end

  generate
    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
      cmpirq_flag flag_i (
        .clk(clk), .rst_n(rst_sync_n), .sw_wr(flag_wr), .sw_val(f_val[g]),
        .hw_set(f_set[g]), .ack(f_ack[g]), .flag_q(f_q[g]));
    end
  endgenerate

  always_comb begin
    flag_view            = '0;
    flag_view[BIT_FLAG6] = f_q[0];
    flag_view[BIT_FLAG7] = f_q[1];
    int6_req             = f_q[0] & f_mask[0];
    int7_req             = f_q[1] & f_mask[1];
    timer_run            = ctrl_view[BIT_TMR_RUN];
    cmp_pins_owned       = cmp_en;
    io_rdata             = '0;
    if (io_rd) begin
      if (io_addr == CTRL_A)      io_rdata = ctrl_view;
      else if (io_addr == FLAG_A) io_rdata = flag_view;
    end
  end

  assert_cmp_off_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cmp_pins_owned |-> !cmp_fall);
  assert_ack_other_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    int7_ack && !int6_ack && !flag_wr && f_q[0] |=> f_q[0]);
endmodule

// File: tb/cmpirq_unit_tb_top.sv
`timescale 1ns/1ps
module cmpirq_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] io_addr = '0;
  logic io_wr = 1'b0, io_rd = 1'b0;
  logic [15:0] io_wdata = '0;
  logic [15:0] io_rdata;
  logic cmp_in = 1'b1, int6_evt = 1'b0, int6_ack = 1'b0, int7_ack = 1'b0;
  logic int6_req, int7_req, timer_run, cmp_pins_owned;
  int total = 0, failed = 0;
  logic [15:0] rd;

  always #2.5 clk = ~clk;

  cmpirq_unit dut_i (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .cmp_in(cmp_in),
    .int6_evt(int6_evt), .int6_ack(int6_ack), .int7_ack(int7_ack),
    .int6_req(int6_req), .int7_req(int7_req), .timer_run(timer_run),
    .cmp_pins_owned(cmp_pins_owned));

  // {addr, wdata, expected readback}
  localparam logic [39:0] VEC [8] = '{
    {8'h38, 16'hFFFF, 16'h84C0}, {8'h38, 16'h0400, 16'h0400},
    {8'h38, 16'h0000, 16'h0000}, {8'h39, 16'hFFFF, 16'h00C0},
    {8'h39, 16'h0040, 16'h0040}, {8'h39, 16'h0080, 16'h0080},
    {8'h39, 16'h0000, 16'h0000}, {8'h20, 16'hFFFF, 16'h0000}};

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle of stimulus, driven at negedge, released at the next negedge
  task automatic step(input logic wr, input logic [7:0] a, input logic [15:0] d,
                      input logic e6, input logic k6, input logic k7);
    @(negedge clk);
    io_wr = wr; io_addr = a; io_wdata = d;
    int6_evt = e6; int6_ack = k6; int7_ack = k7;
    @(negedge clk);
    io_wr = 1'b0; int6_evt = 1'b0; int6_ack = 1'b0; int7_ack = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    step(1'b1, a, d, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic rdreg(input logic [7:0] a, output logic [15:0] v);
    @(negedge clk);
    io_rd = 1'b1; io_addr = a;
    #1 v = io_rdata;
    io_rd = 1'b0;
  endtask

  task automatic cmp_set(input logic v);
    @(negedge clk);
    cmp_in = v;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    failed++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rdreg(8'h38, rd); check("R1 ctrl", rd, 16'h0000);
    rdreg(8'h39, rd); check("R1 flags", rd, 16'h0000);
    check("R1 outputs", {12'h0, int6_req, int7_req, timer_run, cmp_pins_owned}, 16'h0);

    // R2 R5 register table
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][39:32], VEC[i][31:16]);
      rdreg(VEC[i][39:32], rd);
      check("R2 readback", rd, VEC[i][15:0]);
      if (VEC[i][39:32] == 8'h38) begin
        check("R5 timer_run", {15'h0, timer_run}, {15'h0, VEC[i][10]});
        check("R3 pins_owned", {15'h0, cmp_pins_owned}, {15'h0, VEC[i][15]});
      end
    end
    @(negedge clk); io_addr = 8'h38; #1 check("R2 rd low", io_rdata, 16'h0000);

    // R3 disabled comparator: falling edge ignored
    cmp_set(1'b0);
    rdreg(8'h39, rd); check("R3 no flag", rd, 16'h0000);
    check("R3 no timer", {15'h0, timer_run}, 16'h0);
    cmp_set(1'b1);

    // R4 R6 enabled edge sets INT7 and starts timer
    wr(8'h38, 16'h8000);
    check("R3 owned", {15'h0, cmp_pins_owned}, 16'h1);
    cmp_set(1'b0);
    rdreg(8'h39, rd); check("R4 flag7", rd, 16'h0080);
    check("R6 start", {15'h0, timer_run}, 16'h1);

    // R4 held low and rising edge give no new event
    wr(8'h39, 16'h0000);
    repeat (10) @(negedge clk);
    rdreg(8'h39, rd); check("R4 held low", rd, 16'h0000);
    cmp_set(1'b1);
    rdreg(8'h39, rd); check("R4 rising", rd, 16'h0000);

    // R6 INT6 set blocks start
    wr(8'h38, 16'h8000);
    wr(8'h39, 16'h0040);
    cmp_set(1'b0);
    check("R6 blocked", {15'h0, timer_run}, 16'h0);
    rdreg(8'h39, rd); check("R4 flag7 again", rd, 16'h00C0);
    cmp_set(1'b1);

    // R7 R8 R10 masks and acknowledges
    check("R7 masked", {14'h0, int6_req, int7_req}, 16'h0);
    wr(8'h38, 16'h8080);
    check("R7 req7", {14'h0, int6_req, int7_req}, 16'h1);
    step(1'b0, 8'h00, 16'h0, 1'b0, 1'b0, 1'b1);
    rdreg(8'h39, rd); check("R10 ack7 keeps flag6", rd, 16'h0040);
    check("R7 req7 low", {15'h0, int7_req}, 16'h0);
    wr(8'h38, 16'h80C0);
    check("R8 req6", {15'h0, int6_req}, 16'h1);
    step(1'b0, 8'h00, 16'h0, 1'b0, 1'b1, 1'b0);
    rdreg(8'h39, rd); check("R8 ack6 clears", rd, 16'h0000);

    // R8 priority of ack over event, event alone sets
    step(1'b0, 8'h00, 16'h0, 1'b1, 1'b1, 1'b0);
    rdreg(8'h39, rd); check("R8 ack wins", rd, 16'h0000);
    step(1'b0, 8'h00, 16'h0, 1'b1, 1'b0, 1'b1);
    rdreg(8'h39, rd); check("R10 other ack no block", rd, 16'h0040);

    // R7 ack7 beats a same-cycle comparator event
    @(negedge clk); cmp_in = 1'b0;
    @(negedge clk); @(negedge clk);
    int7_ack = 1'b1;  // pulse is high across the edge that would set INT7
    @(negedge clk); int7_ack = 1'b0;
    repeat (3) @(negedge clk);
    rdreg(8'h39, rd); check("R7 ack beats event", rd, 16'h0040);
    cmp_set(1'b1);

    // R9 software write wins
    step(1'b1, 8'h39, 16'h0000, 1'b1, 1'b0, 1'b0);
    rdreg(8'h39, rd); check("R9 write beats event", rd, 16'h0000);
    step(1'b1, 8'h39, 16'h00C0, 1'b0, 1'b1, 1'b1);
    rdreg(8'h39, rd); check("R9 write beats ack", rd, 16'h00C0);

    // R3 disabling releases pins
    wr(8'h38, 16'h0000);
    check("R3 released", {15'h0, cmp_pins_owned}, 16'h0);

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule